// File: doc/BRIEF.md
# Strided Matrix-Row Quad Mover

This block copies four rows of a two-dimensional row store into four consecutive vector registers. It takes the decoded fields of one move instruction and a 32-bit base value. The base comes from one of four scalar registers, and the block names that register on an output. The block forms a starting row inside the first quarter of the row store. It then reads one row from each quarter at a fixed stride and writes each row to the next register of an aligned group of four.

A start pulse launches the sequence. One row moves per clock for four cycles, and a done pulse follows. The block checks two conditions before any transfer. If the move feature is absent, it raises an undefined-instruction flag. If streaming vector mode or the row store is disabled, it raises a trap flag. In both cases it writes nothing.

The row store and the vector register file sit outside the block. The row store is read combinationally during each transfer cycle. The register file takes one full-width write per transfer cycle.

Top module: `quad_row_mover`

## Requirements
- R1: The scalar register index output is 8 plus the 2-bit select field, so only registers 8 to 11 can supply the base.
- R2: The first row read is (base + 3-bit offset) modulo the stride, where the stride is (VL_BITS/8)/4 rows. Overflow of the 32-bit sum does not change the result.
- R3: In transfer cycle r (r = 0..3), the register write address is 4 × (3-bit destination field) + r.
- R4: In transfer cycle r, the row read address is start + r × stride. Rows are visited in ascending order, one per clock.
- R5: The register write data equals the complete row read in the same cycle, with no lane masking.
- R6: busy and reg_wr_en are high for exactly the four cycles after an accepted start. done is high for one cycle, in the cycle after the fourth write.
- R7: If feat_present is low at start, undef_flag pulses for one cycle after the start. No busy cycle and no register write occur. This check takes priority over the enable check.
- R8: If feat_present is high and stream_en or matrix_en is low at start, trap_flag pulses for one cycle after the start. No busy cycle and no register write occur.
- R9: A start pulse that arrives while a transfer is in progress is ignored. The transfer runs unchanged, and no second sequence follows.
- R10: While reset is held, busy, done, undef_flag, trap_flag and reg_wr_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, with the fields valid in the same cycle |
| feat_present | input | 1 | Move feature implemented |
| stream_en | input | 1 | Streaming vector mode enabled |
| matrix_en | input | 1 | Row store enabled |
| sel_field | input | 2 | Scalar base register select |
| off_field | input | 3 | Immediate row offset |
| dst_field | input | 3 | Destination group; the first register is this value times 4 |
| scalar_idx | output | 5 | Scalar register to read for the base |
| base_val | input | 32 | Value of the scalar register named by scalar_idx |
| row_rd_en | output | 1 | Row store read strobe |
| row_rd_addr | output | log2(VL_BITS/8) | Row store read address |
| row_rd_data | input | VL_BITS | Row returned for row_rd_addr in the same cycle |
| reg_wr_en | output | 1 | Vector register write strobe |
| reg_wr_addr | output | 5 | Vector register number |
| reg_wr_data | output | VL_BITS | Vector register write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| undef_flag | output | 1 | One-cycle undefined-instruction pulse |
| trap_flag | output | 1 | One-cycle enable-check trap pulse |

## Verification
The bench builds the block with VL_BITS = 128. This gives 16 rows, a stride of 4 and a 2-bit start index, so a sweep of every select, offset and destination value reaches each start row and each destination group. The base values include zero, small odd numbers and values just below 2^32. These make the base-plus-offset sum wrap, which shows that the modulo depends only on the low bits. Separate runs cover every combination of the feature and enable inputs, and a start pulse injected in the middle of a transfer.

// File: rtl/rowmv_pkg.sv
package rowmv_pkg;
  typedef enum logic [0:0] {
    MV_IDLE = 1'b0,
    MV_MOVE = 1'b1
  } mv_state_e;

  localparam int unsigned GROUP_REGS = 4;
  localparam int unsigned STEP_W     = 2;
  localparam int unsigned SCALAR_W   = 5;
  localparam int unsigned REG_W      = 5;
  localparam logic [2:0]  SCALAR_HI  = 3'b010;
endpackage

// File: rtl/rowmv_decode.sv
module rowmv_decode
  import rowmv_pkg::*;
#(
  parameter int unsigned STRIDE_W = 2
) (
  input  logic [1:0]          sel_i,
  input  logic [2:0]          off_i,
  input  logic [31:0]         base_i,
  output logic [SCALAR_W-1:0] scalar_idx_o,
  output logic [STRIDE_W-1:0] start_row_o
);
  logic [31:0] sum;
  logic        unused_sum_hi;

  // Fixed high bits select the scalar bank 8..11.
  assign scalar_idx_o  = {SCALAR_HI, sel_i};
  assign sum           = base_i + {29'd0, off_i};
  // The stride is a power of two, so the modulo keeps only the low bits.
  assign start_row_o   = sum[STRIDE_W-1:0];
  assign unused_sum_hi = ^sum[31:STRIDE_W];
endmodule

// File: rtl/rowmv_seq.sv
module rowmv_seq
  import rowmv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              feat_i,
  input  logic              en_i,
  output logic              busy_o,
  output logic [STEP_W-1:0] step_o,
  output logic              load_o,
  output logic              done_o,
  output logic              undef_o,
  output logic              trap_o
);
  mv_state_e         st_q, st_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              done_q, done_d;
  logic              undef_q, undef_d;
  logic              trap_q, trap_d;
  logic              accept;

  always_comb begin
    st_d    = st_q;
    step_d  = step_q;
    done_d  = 1'b0;
    undef_d = 1'b0;
    trap_d  = 1'b0;
    accept  = 1'b0;
    case (st_q)
      MV_IDLE: begin
        if (start_i) begin
          if (!feat_i) begin
            undef_d = 1'b1;
          end else if (!en_i) begin
            trap_d = 1'b1;
          end else begin
            accept = 1'b1;
            st_d   = MV_MOVE;
            step_d = '0;
          end
        end
      end
      MV_MOVE: begin
        step_d = step_q + 1'b1;
        if (step_q == STEP_W'(GROUP_REGS - 1)) begin
          st_d   = MV_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = MV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= MV_IDLE;
      step_q  <= '0;
      done_q  <= 1'b0;
      undef_q <= 1'b0;
      trap_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      step_q  <= step_d;
      done_q  <= done_d;
      undef_q <= undef_d;
      trap_q  <= trap_d;
    end
  end

  assign busy_o  = (st_q == MV_MOVE);
  assign step_o  = step_q;
  assign load_o  = accept;
  assign done_o  = done_q;
  assign undef_o = undef_q;
  assign trap_o  = trap_q;
endmodule

// File: rtl/rowmv_addr.sv
module rowmv_addr
  import rowmv_pkg::*;
#(
  parameter int unsigned STRIDE_W = 2,
  parameter int unsigned ROW_W    = STRIDE_W + STEP_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [STRIDE_W-1:0] start_row_i,
  input  logic [2:0]          dst_grp_i,
  input  logic [STEP_W-1:0]   step_i,
  output logic [ROW_W-1:0]    rd_addr_o,
  output logic [REG_W-1:0]    wr_addr_o
);
  logic [STRIDE_W-1:0] start_q, start_d;
  logic [2:0]          dst_q, dst_d;

  always_comb begin
    start_d = start_q;
    dst_d   = dst_q;
    if (load_i) begin
      start_d = start_row_i;
      dst_d   = dst_grp_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      dst_q   <= '0;
    end else begin
      start_q <= start_d;
      dst_q   <= dst_d;
    end
  end

  // The quarter number is the high part of the row address, so start + step*stride.
  assign rd_addr_o = {step_i, start_q};
  // The register group is aligned to four, so the step fills the low two bits.
  assign wr_addr_o = {dst_q, step_i};
endmodule

// File: rtl/quad_row_mover.sv
module quad_row_mover
  import rowmv_pkg::*;
#(
  parameter  int unsigned VL_BITS  = 128,
  localparam int unsigned ROWS     = VL_BITS / 8,
  localparam int unsigned STRIDE   = ROWS / GROUP_REGS,
  localparam int unsigned STRIDE_W = $clog2(STRIDE),
  localparam int unsigned ROW_W    = $clog2(ROWS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                feat_present,
  input  logic                stream_en,
  input  logic                matrix_en,
  input  logic [1:0]          sel_field,
  input  logic [2:0]          off_field,
  input  logic [2:0]          dst_field,
  output logic [SCALAR_W-1:0] scalar_idx,
  input  logic [31:0]         base_val,
  output logic                row_rd_en,
  output logic [ROW_W-1:0]    row_rd_addr,
  input  logic [VL_BITS-1:0]  row_rd_data,
  output logic                reg_wr_en,
  output logic [REG_W-1:0]    reg_wr_addr,
  output logic [VL_BITS-1:0]  reg_wr_data,
  output logic                busy,
  output logic                done,
  output logic                undef_flag,
  output logic                trap_flag
);
  logic [STRIDE_W-1:0] start_row;
  logic [STEP_W-1:0]   step;
  logic                load;
  logic                en_ok;

  assign en_ok = stream_en & matrix_en;

  rowmv_decode #(.STRIDE_W(STRIDE_W)) u_dec (
    .sel_i        (sel_field),
    .off_i        (off_field),
    .base_i       (base_val),
    .scalar_idx_o (scalar_idx),
    .start_row_o  (start_row)
  );

  rowmv_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .feat_i  (feat_present),
    .en_i    (en_ok),
    .busy_o  (busy),
    .step_o  (step),
    .load_o  (load),
    .done_o  (done),
    .undef_o (undef_flag),
    .trap_o  (trap_flag)
  );

  rowmv_addr #(.STRIDE_W(STRIDE_W), .ROW_W(ROW_W)) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load),
    .start_row_i (start_row),
    .dst_grp_i   (dst_field),
    .step_i      (step),
    .rd_addr_o   (row_rd_addr),
    .wr_addr_o   (reg_wr_addr)
  );

  // Unpredicated move: the whole row passes through.
  assign row_rd_en   = busy;
  assign reg_wr_en   = busy;
  assign reg_wr_data = row_rd_data;
endmodule

// File: rtl/quad_row_mover_chk.sv
module quad_row_mover_chk #(
  parameter  int unsigned VL_BITS = 128,
  localparam int unsigned ROWS    = VL_BITS / 8,
  localparam int unsigned STRIDE  = ROWS / 4,
  localparam int unsigned ROW_W   = $clog2(ROWS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             undef_flag,
  input logic             trap_flag,
  input logic [ROW_W-1:0] row_rd_addr,
  input logic [4:0]       reg_wr_addr
);
  assert_row_stride_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (row_rd_addr == ROW_W'($past(row_rd_addr) + STRIDE)));

  assert_first_quarter_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (row_rd_addr < ROW_W'(STRIDE)));

  assert_reg_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (reg_wr_addr == 5'($past(reg_wr_addr) + 5'd1)));

  assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_undef_no_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
    undef_flag |-> (!busy && !trap_flag));

  assert_trap_no_move_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_flag |-> (!busy && !undef_flag));

  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && (row_rd_addr >= ROW_W'(STRIDE))) |=> (busy || done));
endmodule

bind quad_row_mover quad_row_mover_chk #(.VL_BITS(VL_BITS)) u_chk (.*);

// File: tb/sim_quad_row_mover.sv
`timescale 1ns/1ps
module sim_quad_row_mover;
  localparam int VL = 128;
  localparam int ROWS = VL / 8;
  localparam int STRIDE = ROWS / 4;
  localparam int ROW_W = $clog2(ROWS);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start, feat_present, stream_en, matrix_en;
  logic [1:0]        sel_field;
  logic [2:0]        off_field, dst_field;
  logic [4:0]        scalar_idx;
  logic [31:0]       base_val;
  logic              row_rd_en;
  logic [ROW_W-1:0]  row_rd_addr;
  logic [VL-1:0]     row_rd_data;
  logic              reg_wr_en;
  logic [4:0]        reg_wr_addr;
  logic [VL-1:0]     reg_wr_data;
  logic              busy, done, undef_flag, trap_flag;
  logic [31:0]       xreg [32];
  int                n_chk = 0;
  int                n_fail = 0;

  always #2 clk = ~clk;

  function automatic logic [VL-1:0] row_pat(input int i);
    logic [VL-1:0] v;
    for (int ln = 0; ln < VL / 32; ln++)
      v[ln*32 +: 32] = 32'h5A5A0000 + 32'(i) * 32'h01010101 + 32'(ln) * 32'h10000001;
    return v;
  endfunction

  assign row_rd_data = row_pat(int'(row_rd_addr));
  assign base_val    = xreg[scalar_idx];

  quad_row_mover #(.VL_BITS(VL)) u0 (.*);

  task automatic check(input bit ok, input string req,
                       input logic [VL-1:0] act, input logic [VL-1:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic move_op(input int sel, input int off, input int dst,
                         input bit feat, input bit se, input bit me, input bit poke);
    int st;
    int exp_row;
    @(negedge clk);
    sel_field = 2'(sel); off_field = 3'(off); dst_field = 3'(dst);
    feat_present = feat; stream_en = se; matrix_en = me; start = 1'b1;
    #1;
    check(scalar_idx == 5'(8 + sel), "R1 scalar index", VL'(scalar_idx), VL'(8 + sel));
    st = int'((longint'(xreg[8 + sel]) + longint'(off)) % STRIDE);
    @(negedge clk);
    start = 1'b0;
    if (!feat) begin
      check(undef_flag && !trap_flag && !busy && !reg_wr_en, "R7 undef pulse",
            VL'({undef_flag, trap_flag, busy, reg_wr_en}), VL'(4'b1000));
      @(negedge clk);
      check(!undef_flag && !busy && !reg_wr_en, "R7 single pulse",
            VL'({undef_flag, busy, reg_wr_en}), VL'(0));
    end else if (!(se && me)) begin
      check(trap_flag && !undef_flag && !busy && !reg_wr_en, "R8 trap pulse",
            VL'({trap_flag, undef_flag, busy, reg_wr_en}), VL'(4'b1000));
      @(negedge clk);
      check(!trap_flag && !busy && !reg_wr_en, "R8 single pulse",
            VL'({trap_flag, busy, reg_wr_en}), VL'(0));
    end else begin
      for (int k = 0; k < 4; k++) begin
        exp_row = st + k * STRIDE;
        check(busy && reg_wr_en && !done, "R6 busy window",
              VL'({busy, reg_wr_en, done}), VL'(3'b110));
        if (k == 0)
          check(row_rd_addr == ROW_W'(exp_row), "R2 start row",
                VL'(row_rd_addr), VL'(exp_row));
        else
          check(row_rd_addr == ROW_W'(exp_row), "R4 strided row",
                VL'(row_rd_addr), VL'(exp_row));
        check(reg_wr_addr == 5'(dst * 4 + k), "R3 dest reg",
              VL'(reg_wr_addr), VL'(dst * 4 + k));
        check(reg_wr_data == row_pat(exp_row), "R5 full row data",
              reg_wr_data, row_pat(exp_row));
        if (poke && k == 1) begin
          off_field = 3'(off + 1); dst_field = 3'(dst + 1); start = 1'b1;
        end
        @(negedge clk);
        start = 1'b0;
      end
      check(done && !busy && !reg_wr_en, "R6 done pulse",
            VL'({done, busy, reg_wr_en}), VL'(3'b100));
      @(negedge clk);
      if (poke)
        check(!done && !busy && !reg_wr_en, "R9 mid-move start ignored",
              VL'({done, busy, reg_wr_en}), VL'(0));
      else
        check(!done && !busy, "R6 done single", VL'({done, busy}), VL'(0));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) xreg[i] = 32'(i * 7);
    rst_n = 1'b0; start = 1'b0; feat_present = 1'b1; stream_en = 1'b1; matrix_en = 1'b1;
    sel_field = '0; off_field = '0; dst_field = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !undef_flag && !trap_flag && !reg_wr_en, "R10 reset state",
          VL'({busy, done, undef_flag, trap_flag, reg_wr_en}), VL'(0));
    rst_n = 1'b1;

    for (int pass = 0; pass < 2; pass++) begin
      if (pass == 0) begin
        xreg[8] = 32'h0; xreg[9] = 32'h3; xreg[10] = 32'hFFFF_FFFE; xreg[11] = 32'h7FFF_FFFD;
      end else begin
        xreg[8] = 32'hFFFF_FFFF; xreg[9] = 32'h1234_5671; xreg[10] = 32'h2; xreg[11] = 32'hFFFF_FFF9;
      end
      for (int s = 0; s < 4; s++)
        for (int o = 0; o < 8; o++)
          for (int d = 0; d < 8; d++)
            move_op(s, o, d, 1'b1, 1'b1, 1'b1, 1'b0);
    end

    // Feature absent wins over the enables (R7); enable combinations (R8).
    move_op(1, 2, 3, 1'b0, 1'b1, 1'b1, 1'b0);
    move_op(2, 5, 6, 1'b0, 1'b0, 1'b0, 1'b0);
    move_op(0, 1, 1, 1'b1, 1'b0, 1'b1, 1'b0);
    move_op(3, 7, 4, 1'b1, 1'b1, 1'b0, 1'b0);
    move_op(2, 0, 7, 1'b1, 1'b0, 1'b0, 1'b0);
    // Start pulses during a transfer (R9).
    move_op(0, 3, 2, 1'b1, 1'b1, 1'b1, 1'b1);
    move_op(3, 6, 7, 1'b1, 1'b1, 1'b1, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule